// File: doc/BRIEF.md
# Single-Accumulator Multicycle Processor Core

This block is a small multicycle processor that keeps its one working value in an accumulator register. Each instruction names at most one memory location, and the accumulator is both the implied source and the implied destination. Because of this, the expression A = B*C + D is four instructions (load, multiply, add, store) and twelve program bytes. Instructions and data share one byte-addressed memory. The core reaches that memory through a synchronous port that moves one byte per cycle.

An instruction is three bytes long: an opcode byte, then a 16-bit operand address stored high byte first. Data words are 16 bits and are also stored high byte first. The control state machine has these states: `ST_FETCH` (read the opcode at pc), `ST_DECODE` (take the opcode and, for a memory opcode, read the address high byte), `ST_ADDR_HI` (take the high byte and read the low byte), `ST_ADDR_LO` (take the low byte), `ST_OPND_HI` and `ST_OPND_LO` (read the operand word), `ST_EXEC` (update the accumulator and step pc), `ST_STORE_HI` and `ST_STORE_LO` (write the accumulator), `ST_HALT` and `ST_TRAP`.

The transitions are:
- FETCH always goes to DECODE.
- DECODE goes to HALT on the halt opcode, to ADDR_HI on a memory opcode, and to TRAP on any other value.
- ADDR_HI goes to ADDR_LO.
- ADDR_LO goes to STORE_HI for a store and to OPND_HI for every other opcode.
- OPND_HI goes to OPND_LO, then EXEC, then back to FETCH.
- STORE_HI goes to STORE_LO, then back to FETCH.
- HALT and TRAP hold until reset.

A counter adds one for every byte that crosses the memory port, so the traffic of a program can be measured.

Top module: `acc_core`

## Requirements
- R1: After reset, pc, the accumulator and the byte counter are 0, both halted and illegal are 0, and the first access is a read of address 0.
- R2: An instruction is an opcode byte at pc, then the operand address with its high byte at pc+1 and its low byte at pc+2. After every completed load, store, add or multiply, pc grows by 3.
- R3: Opcode 0x01 (load) puts the 16-bit word at the operand address into the accumulator. The high byte comes from the address and the low byte from the address plus one. Read data is taken on the cycle after `mem_rd`.
- R4: Opcode 0x02 (store) writes the accumulator's high byte to the operand address and its low byte to the address plus one. It leaves the accumulator unchanged.
- R5: Opcode 0x03 (add) adds the addressed word to the accumulator, modulo 2^16.
- R6: Opcode 0x04 (multiply) replaces the accumulator with the low 16 bits of the accumulator times the addressed word.
- R7: Opcode 0xFF (halt) sets `halted` after one opcode byte has been read. pc stays at the halt byte's address, and no further memory access happens until reset.
- R8: Any other opcode sets `illegal` and `halted` without reading any address bytes. After that the core makes no more accesses.
- R9: `byte_count` grows by exactly one for each cycle with `mem_rd` or `mem_wr` high. The program A = B*C + D followed by halt moves 21 bytes: 20 for the four instructions and 1 for the halt opcode.
- R10: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 16 | Byte address of the current access |
| mem_rd | output | 1 | Read request; data is returned on `mem_rdata` one cycle later |
| mem_wr | output | 1 | Write request; `mem_wdata` is stored at `mem_addr` on this clock edge |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte returned for the previous cycle's read |
| acc | output | 16 | Accumulator |
| pc | output | 16 | Program counter |
| halted | output | 1 | Core has stopped (halt opcode or illegal opcode) |
| illegal | output | 1 | Core stopped on an unknown opcode |
| byte_count | output | CNT_W (32) | Number of bytes moved over the memory port since reset |

## Verification
A read byte returns on the cycle after its request. The accumulator changes at the edge that leaves `ST_EXEC`, and the counter steps at the edge that ends each access. `halted` rises at the edge that leaves `ST_DECODE` of a halt or unknown opcode. The bench samples only on falling edges. It checks the reset values in the half cycle after reset is released, before any edge. Every other result is read only once `halted` is seen, when the final values have settled. An independent bus monitor counts accesses and overlapping read/write cycles at each rising edge, for comparison with the core's counter.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

    localparam int BYTE_W    = 8;
    localparam int WORD_W    = 2 * BYTE_W;
    localparam int ADDR_W    = 2 * BYTE_W;
    localparam int INSTR_LEN = 3;

    localparam logic [BYTE_W-1:0] OPC_LOAD  = 8'h01;
    localparam logic [BYTE_W-1:0] OPC_STORE = 8'h02;
    localparam logic [BYTE_W-1:0] OPC_ADD   = 8'h03;
    localparam logic [BYTE_W-1:0] OPC_MUL   = 8'h04;
    localparam logic [BYTE_W-1:0] OPC_HALT  = 8'hFF;

    typedef enum logic [3:0] {
        ST_FETCH,
        ST_DECODE,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_OPND_HI,
        ST_OPND_LO,
        ST_EXEC,
        ST_STORE_HI,
        ST_STORE_LO,
        ST_HALT,
        ST_TRAP
    } core_state_t;

    function automatic logic opc_takes_address(input logic [BYTE_W-1:0] b);
        return (b == OPC_LOAD) || (b == OPC_STORE) ||
               (b == OPC_ADD)  || (b == OPC_MUL);
    endfunction

endpackage

// File: rtl/acc_core_alu.sv
module acc_core_alu
    import acc_core_pkg::*;
(
    input  logic [BYTE_W-1:0] opc,
    input  logic [WORD_W-1:0] acc_in,
    input  logic [WORD_W-1:0] mem_word,
    output logic [WORD_W-1:0] result
);

    // Sums and products are taken in WORD_W bits, so both wrap modulo 2^16.
    always_comb begin
        case (opc)
            OPC_LOAD: result = mem_word;
            OPC_ADD:  result = acc_in + mem_word;
            OPC_MUL:  result = acc_in * mem_word;
            default:  result = acc_in;
        endcase
    end

endmodule

// File: rtl/acc_core_ctrl.sv
module acc_core_ctrl
    import acc_core_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] rd_byte,
    input  logic [BYTE_W-1:0] op_q,
    output core_state_t       state,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              halted,
    output logic              illegal
);

    core_state_t state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_FETCH;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FETCH:    state_nx = ST_DECODE;
            ST_DECODE: begin
                if (rd_byte == OPC_HALT)              state_nx = ST_HALT;
                else if (opc_takes_address(rd_byte))  state_nx = ST_ADDR_HI;
                else                                  state_nx = ST_TRAP;
            end
            ST_ADDR_HI:  state_nx = ST_ADDR_LO;
            ST_ADDR_LO:  state_nx = (op_q == OPC_STORE) ? ST_STORE_HI : ST_OPND_HI;
            ST_OPND_HI:  state_nx = ST_OPND_LO;
            ST_OPND_LO:  state_nx = ST_EXEC;
            ST_EXEC:     state_nx = ST_FETCH;
            ST_STORE_HI: state_nx = ST_STORE_LO;
            ST_STORE_LO: state_nx = ST_FETCH;
            ST_HALT:     state_nx = ST_HALT;
            ST_TRAP:     state_nx = ST_TRAP;
            default:     state_nx = ST_TRAP;
        endcase
    end

    always_comb begin
        mem_rd  = 1'b0;
        mem_wr  = 1'b0;
        halted  = 1'b0;
        illegal = 1'b0;
        unique case (state)
            ST_FETCH, ST_ADDR_HI, ST_OPND_HI, ST_OPND_LO: mem_rd = 1'b1;
            ST_DECODE:               mem_rd = opc_takes_address(rd_byte);
            ST_STORE_HI, ST_STORE_LO: mem_wr = 1'b1;
            ST_HALT:                 halted = 1'b1;
            ST_TRAP: begin
                halted  = 1'b1;
                illegal = 1'b1;
            end
            default: ;
        endcase
    end

    // R10: one byte per cycle, never read and write together
    a_r10_single_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R7: once stopped, the core stays stopped
    a_r7_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R8: an unknown opcode leaves the port silent afterwards
    a_r8_trap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> (!mem_rd && !mem_wr));

endmodule

// File: rtl/acc_core_dp.sv
module acc_core_dp
    import acc_core_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  core_state_t       state,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic [WORD_W-1:0] acc,
    output logic [ADDR_W-1:0] pc,
    output logic [BYTE_W-1:0] op_q
);

    localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(INSTR_LEN);

    logic [ADDR_W-1:0] ea_q;
    logic [BYTE_W-1:0] opnd_hi_q;
    logic [WORD_W-1:0] alu_y;

    acc_core_alu u_alu (
        .opc      (op_q),
        .acc_in   (acc),
        .mem_word ({opnd_hi_q, mem_rdata}),
        .result   (alu_y)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc       <= '0;
            pc        <= '0;
            ea_q      <= '0;
            op_q      <= '0;
            opnd_hi_q <= '0;
        end else begin
            unique case (state)
                ST_DECODE:   op_q <= mem_rdata;
                ST_ADDR_HI:  ea_q[ADDR_W-1:BYTE_W] <= mem_rdata;
                ST_ADDR_LO:  ea_q[BYTE_W-1:0] <= mem_rdata;
                ST_OPND_LO:  opnd_hi_q <= mem_rdata;
                ST_EXEC: begin
                    acc <= alu_y;
                    pc  <= pc + PC_STEP;
                end
                ST_STORE_LO: pc <= pc + PC_STEP;
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            ST_DECODE:               mem_addr = pc + ADDR_W'(1);
            ST_ADDR_HI:              mem_addr = pc + ADDR_W'(2);
            ST_OPND_HI, ST_STORE_HI: mem_addr = ea_q;
            ST_OPND_LO, ST_STORE_LO: mem_addr = ea_q + ADDR_W'(1);
            default:                 mem_addr = pc;
        endcase
    end

    assign mem_wdata = (state == ST_STORE_HI) ? acc[WORD_W-1:BYTE_W] : acc[BYTE_W-1:0];

    // R2: pc steps by one instruction length after each completed instruction
    a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC || state == ST_STORE_LO) |=> (pc == $past(pc) + PC_STEP));

    // R4: only the execute step may change the accumulator
    a_r4_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_EXEC) |=> $stable(acc));

endmodule

// File: rtl/acc_core_cnt.sv
module acc_core_cnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   count <= '0;
        else if (inc) count <= count + CNT_W'(1);
    end

endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_core_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] acc,
    output logic [ADDR_W-1:0] pc,
    output logic              halted,
    output logic              illegal,
    output logic [CNT_W-1:0]  byte_count
);

    core_state_t       state;
    logic [BYTE_W-1:0] op_q;

    acc_core_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_byte (mem_rdata),
        .op_q    (op_q),
        .state   (state),
        .mem_rd  (mem_rd),
        .mem_wr  (mem_wr),
        .halted  (halted),
        .illegal (illegal)
    );

    acc_core_dp u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .acc       (acc),
        .pc        (pc),
        .op_q      (op_q)
    );

    acc_core_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (mem_rd || mem_wr),
        .count (byte_count)
    );

    // R9: the counter holds in any cycle without a port access
    a_r9_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd || mem_wr) |=> $stable(byte_count));

    // R8: the illegal flag never appears without the core being stopped
    a_r8_illegal_halts: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> halted);

    // R7: a stopped core holds its program counter
    a_r7_pc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(pc));

endmodule

// File: tb/acc_core_test.sv
`timescale 1ns/1ps
module acc_core_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;
    logic [15:0] acc, pc;
    logic        halted, illegal;
    logic [31:0] byte_count;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [7:0] ram [256];
    logic       tb_we = 1'b0;
    logic [7:0] tb_addr = 8'h00;
    logic [7:0] tb_data = 8'h00;
    int         mon_cnt;
    int         both_cnt;

    always #2 clk = ~clk;

    acc_core uut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .acc(acc), .pc(pc), .halted(halted), .illegal(illegal),
        .byte_count(byte_count)
    );

    // synchronous byte memory with a bench load port
    always @(posedge clk) begin
        if (mem_wr && rst_n) ram[mem_addr[7:0]] <= mem_wdata;
        else if (tb_we)      ram[tb_addr] <= tb_data;
        if (mem_rd) mem_rdata <= ram[mem_addr[7:0]];
    end

    // independent bus monitor
    always @(posedge clk) begin
        if (!rst_n) begin
            mon_cnt  <= 0;
            both_cnt <= 0;
        end else begin
            if (mem_rd || mem_wr) mon_cnt <= mon_cnt + 1;
            if (mem_rd && mem_wr) both_cnt <= both_cnt + 1;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog actual=%0d expected<=150000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [7:0] a, input logic [7:0] d);
        tb_addr = a;
        tb_data = d;
        tb_we   = 1'b1;
        @(negedge clk);
        tb_we   = 1'b0;
    endtask

    task automatic poke_word(input logic [7:0] a, input logic [15:0] w);
        poke(a, w[15:8]);
        poke(a + 8'd1, w[7:0]);
    endtask

    task automatic poke_instr(input logic [7:0] a, input logic [7:0] op, input logic [7:0] ea);
        poke(a, op);
        poke(a + 8'd1, 8'h00);
        poke(a + 8'd2, ea);
    endtask

    task automatic enter_reset();
        rst_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 80; i++) poke(8'(i), 8'h00);
    endtask

    task automatic run_to_halt();
        bit done = 0;
        rst_n = 1'b1;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (halted) begin
                done = 1;
                break;
            end
        end
        if (!done) begin
            errors++;
            $display("FAIL watchdog run actual=running expected=halted");
        end
    endtask

    // op, B, C, expected accumulator after: load B; op C; store; halt
    localparam logic [55:0] VEC [8] = '{
        {8'h03, 16'h1234, 16'h0101, 16'h1335},
        {8'h03, 16'hFFFF, 16'h0002, 16'h0001},
        {8'h04, 16'h0003, 16'h0005, 16'h000F},
        {8'h04, 16'h0100, 16'h0100, 16'h0000},
        {8'h04, 16'h1234, 16'h0010, 16'h2340},
        {8'h01, 16'h1111, 16'hBEEF, 16'hBEEF},
        {8'h04, 16'hFFFF, 16'hFFFF, 16'h0001},
        {8'h03, 16'h8000, 16'h8000, 16'h0000}
    };

    initial begin
        // vector table: R3 R4 R5 R6 R2 R9 R10
        for (int i = 0; i < 8; i++) begin
            logic [7:0]  op;
            logic [15:0] b, c, e;
            {op, b, c, e} = VEC[i];
            enter_reset();
            poke_instr(8'h00, 8'h01, 8'h40);
            poke_instr(8'h03, op,    8'h42);
            poke_instr(8'h06, 8'h02, 8'h44);
            poke(8'h09, 8'hFF);
            poke_word(8'h40, b);
            poke_word(8'h42, c);
            run_to_halt();
            chk($sformatf("R5/R6/R3 acc vec%0d", i), 32'(acc), 32'(e));
            chk($sformatf("R4 store hi vec%0d", i), 32'(ram[8'h44]), 32'(e[15:8]));
            chk($sformatf("R4 store lo vec%0d", i), 32'(ram[8'h45]), 32'(e[7:0]));
            chk($sformatf("R2 pc vec%0d", i), 32'(pc), 32'h9);
            chk($sformatf("R9 count vec%0d", i), byte_count, 32'd16);
            chk($sformatf("R9 monitor vec%0d", i), 32'(mon_cnt), byte_count);
            chk($sformatf("R10 overlap vec%0d", i), 32'(both_cnt), 32'd0);
        end

        // R1: reset values after a run left nonzero state, and the example program
        enter_reset();
        poke_instr(8'h00, 8'h01, 8'h20);
        poke_instr(8'h03, 8'h04, 8'h22);
        poke_instr(8'h06, 8'h03, 8'h24);
        poke_instr(8'h09, 8'h02, 8'h26);
        poke(8'h0C, 8'hFF);
        poke_word(8'h20, 16'd7);
        poke_word(8'h22, 16'd6);
        poke_word(8'h24, 16'd5);
        rst_n = 1'b1;
        #1;
        chk("R1 acc", 32'(acc), 32'h0);
        chk("R1 pc", 32'(pc), 32'h0);
        chk("R1 count", byte_count, 32'h0);
        chk("R1 flags", {30'h0, halted, illegal}, 32'h0);
        chk("R1 first read", {15'h0, mem_rd, mem_addr}, 32'h0001_0000);
        run_to_halt();
        chk("R9 A=B*C+D acc", 32'(acc), 32'h002F);
        chk("R9 A=B*C+D stored", {16'h0, ram[8'h26], ram[8'h27]}, 32'h002F);
        chk("R9 A=B*C+D traffic", byte_count, 32'd21);
        chk("R2 A=B*C+D pc", 32'(pc), 32'd12);

        // R7: halt as the very first opcode, then silence
        enter_reset();
        poke(8'h00, 8'hFF);
        run_to_halt();
        chk("R7 halt count", byte_count, 32'd1);
        chk("R7 halt pc", 32'(pc), 32'h0);
        chk("R7 halt not illegal", 32'(illegal), 32'h0);
        repeat (10) @(negedge clk);
        chk("R7 halt quiet count", byte_count, 32'd1);
        chk("R7 halt quiet port", {30'h0, mem_rd, mem_wr}, 32'h0);
        chk("R7 halt held", 32'(halted), 32'h1);

        // R8: unknown opcode after a load
        enter_reset();
        poke_instr(8'h00, 8'h01, 8'h30);
        poke(8'h03, 8'h55);
        poke_word(8'h30, 16'hA5C3);
        run_to_halt();
        chk("R8 illegal flag", {30'h0, halted, illegal}, 32'h3);
        chk("R8 acc kept", 32'(acc), 32'hA5C3);
        chk("R8 pc at bad opcode", 32'(pc), 32'h3);
        chk("R8 no address bytes", byte_count, 32'd6);
        repeat (10) @(negedge clk);
        chk("R8 trap quiet", byte_count, 32'd6);

        // R8: opcode 0x00 at address 0
        enter_reset();
        run_to_halt();
        chk("R8 zero opcode", {30'h0, halted, illegal}, 32'h3);
        chk("R8 zero opcode count", byte_count, 32'd1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule